// File: doc/BRIEF.md
# Supply Undervoltage Lockout Gate

This block sits between the control logic of a half-bridge gate driver and its two output stages. An external converter samples two supplies, the ground-referenced supply of the low-side stage and the floating supply of the high-side stage. Each sample arrives as an unsigned code. For each supply the block keeps a "good" flag. The flag uses a rising threshold and a lower falling threshold, and a crossing counts only after it has persisted for a programmable number of clock cycles. Short dips therefore never cause a lockout.

The two flags gate the two drive commands, and the two sides follow different rules. A bad low-side supply silences both outputs. A bad high-side supply silences only the high-side output. When the low side recovers, its output takes the current command level at once. When the high side recovers, its output waits for a fresh rising edge of its command.

One parameter selects between two threshold profiles. The IGBT profile gives the low side higher thresholds than the high side, which helps bootstrap start-up. The MOSFET profile uses one pair of thresholds for both sides. All thresholds are parameters in converter codes. The defaults assume 25 mV per code, and the default filter of 360 cycles is 1.8 µs at 200 MHz.

Top module: `supply_lockout_gate`

## Requirements
- R1: The low-side flag `lo_sup_ok` becomes 1 only after `lo_sup_code` >= LO_ON, and becomes 0 only after `lo_sup_code` < LO_OFF. A code in between leaves the flag as it is. IGBT defaults: LO_ON = 500 (12.5 V), LO_OFF = 464 (11.6 V).
- R2: The high-side flag `hi_sup_ok` follows the same rule with HI_ON and HI_OFF. IGBT defaults: HI_ON = 464 (11.6 V), HI_OFF = 428 (10.7 V).
- R3: With PROFILE = PROF_MOSFET, both sides use ON = 364 (9.1 V) and OFF = 332 (8.3 V).
- R4: A flag changes state only at the FILT_CYC-th consecutive clock edge at which the code lies beyond the threshold for a change. A shorter excursion leaves the flag unchanged.
- R5: While `lo_sup_ok` is 0, both `lo_drv` and `hi_drv` are 0 in the following cycle, whatever the commands or the high-side flag.
- R6: While `hi_sup_ok` is 0, `hi_drv` is 0 in the following cycle, and `lo_drv` still follows `lo_cmd`.
- R7: While `lo_sup_ok` is 1, `lo_drv` equals `lo_cmd` delayed by one clock. After a low-side recovery it takes the command level with no edge needed.
- R8: `hi_drv` turns on only one cycle after a rising edge of `hi_cmd`, and that edge must be sampled while both flags are 1. It stays on while `hi_cmd` stays 1 and both flags stay 1. A command held high across any recovery does not turn it on.
- R9: During reset (`rst_n` = 0), both flags and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_sup_code | input | CODE_W | Low-side supply sample |
| hi_sup_code | input | CODE_W | Floating high-side supply sample |
| lo_cmd | input | 1 | Low-side drive command |
| hi_cmd | input | 1 | High-side drive command |
| lo_drv | output | 1 | Gated low-side drive |
| hi_drv | output | 1 | Gated high-side drive |
| lo_sup_ok | output | 1 | Low-side supply good flag |
| hi_sup_ok | output | 1 | High-side supply good flag |

## Verification
The assertions check on every cycle the gating rules of R5 to R8: outputs forced low by the flags, the one-cycle following of the low-side command, and a high-side turn-on only after a sampled rising edge. They also check that each flag transition was preceded by a code on the correct side of its threshold. The bench's scenarios cover the rest. These are the exact length of the filter window and a dip one cycle too short, codes exactly on each threshold and inside the hysteresis band, and a command held high across a recovery. A second instance covers the MOSFET profile.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;

  typedef enum logic { PROF_IGBT = 1'b0, PROF_MOSFET = 1'b1 } profile_e;

  // True when the code lies beyond the threshold that would change the flag
  function automatic logic crossing_pending(input logic ok, input logic [15:0] code,
                                            input logic [15:0] on_code,
                                            input logic [15:0] off_code);
    if (ok) return code < off_code;
    else    return code >= on_code;
  endfunction

  // Next high-side drive level: turn on only on an edge, hold while command high
  function automatic logic hs_next(input logic supplies_ok, input logic cmd,
                                   input logic rise, input logic drv_now);
    return supplies_ok & cmd & (drv_now | rise);
  endfunction

endpackage

// File: rtl/uvlo_filter.sv
module uvlo_filter #(
  parameter int CODE_W   = 10,
  parameter int FILT_CYC = 360,
  parameter int ON_CODE  = 500,
  parameter int OFF_CODE = 464
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              ok,
  output logic              flip_evt
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             pend;

  assign pend     = uvlo_pkg::crossing_pending(ok, 16'(code), 16'(ON_CODE), 16'(OFF_CODE));
  assign flip_evt = pend && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok  <= 1'b0;
      cnt <= '0;
    end else if (!pend) begin
      cnt <= '0;
    end else if (flip_evt) begin
      ok  <= ~ok;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hs_edge_gate.sv
module hs_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_ok,
  input  logic hi_ok,
  input  logic lo_cmd,
  input  logic hi_cmd,
  output logic lo_drv,
  output logic hi_drv,
  output logic rise_evt
);
  logic cmd_q;
  logic both_ok;

  assign both_ok  = lo_ok & hi_ok;
  assign rise_evt = hi_cmd & ~cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      lo_drv <= 1'b0;
      hi_drv <= 1'b0;
    end else begin
      cmd_q  <= hi_cmd;
      lo_drv <= lo_ok & lo_cmd;
      hi_drv <= uvlo_pkg::hs_next(both_ok, hi_cmd, rise_evt, hi_drv);
    end
  end
endmodule

// File: rtl/supply_lockout_gate.sv
module supply_lockout_gate #(
  parameter int                  CODE_W      = 10,
  parameter int                  FILT_CYC    = 360,
  parameter uvlo_pkg::profile_e  PROFILE     = uvlo_pkg::PROF_IGBT,
  parameter int                  IGBT_LO_ON  = 500,
  parameter int                  IGBT_LO_OFF = 464,
  parameter int                  IGBT_HI_ON  = 464,
  parameter int                  IGBT_HI_OFF = 428,
  parameter int                  MOS_ON      = 364,
  parameter int                  MOS_OFF     = 332
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] lo_sup_code,
  input  logic [CODE_W-1:0] hi_sup_code,
  input  logic              lo_cmd,
  input  logic              hi_cmd,
  output logic              lo_drv,
  output logic              hi_drv,
  output logic              lo_sup_ok,
  output logic              hi_sup_ok
);
  localparam bit IS_IGBT = (PROFILE == uvlo_pkg::PROF_IGBT);
  localparam int LO_ON   = IS_IGBT ? IGBT_LO_ON  : MOS_ON;
  localparam int LO_OFF  = IS_IGBT ? IGBT_LO_OFF : MOS_OFF;
  localparam int HI_ON   = IS_IGBT ? IGBT_HI_ON  : MOS_ON;
  localparam int HI_OFF  = IS_IGBT ? IGBT_HI_OFF : MOS_OFF;

  logic [CODE_W-1:0] codes [2];
  logic [1:0]        sup_ok;
  logic [1:0]        flip_evts;
  logic              lo_flip_evt;
  logic              hi_flip_evt;
  logic              hs_rise_evt;

  assign codes[0] = lo_sup_code;
  assign codes[1] = hi_sup_code;

  // index 0: low-side supply, index 1: floating high-side supply
  for (genvar s = 0; s < 2; s++) begin : g_side
    uvlo_filter #(
      .CODE_W  (CODE_W),
      .FILT_CYC(FILT_CYC),
      .ON_CODE ((s == 0) ? LO_ON  : HI_ON),
      .OFF_CODE((s == 0) ? LO_OFF : HI_OFF)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (codes[s]),
      .ok      (sup_ok[s]),
      .flip_evt(flip_evts[s])
    );
  end

  assign lo_sup_ok   = sup_ok[0];
  assign hi_sup_ok   = sup_ok[1];
  assign lo_flip_evt = flip_evts[0];
  assign hi_flip_evt = flip_evts[1];

  hs_edge_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_ok   (lo_sup_ok),
    .hi_ok   (hi_sup_ok),
    .lo_cmd  (lo_cmd),
    .hi_cmd  (hi_cmd),
    .lo_drv  (lo_drv),
    .hi_drv  (hi_drv),
    .rise_evt(hs_rise_evt)
  );
endmodule

// File: rtl/supply_lockout_chk.sv
module supply_lockout_chk #(
  parameter int CODE_W = 10,
  parameter int LO_ON  = 500,
  parameter int LO_OFF = 464,
  parameter int HI_ON  = 464,
  parameter int HI_OFF = 428
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] lo_sup_code,
  input logic [CODE_W-1:0] hi_sup_code,
  input logic              lo_cmd,
  input logic              hi_cmd,
  input logic              lo_drv,
  input logic              hi_drv,
  input logic              lo_sup_ok,
  input logic              hi_sup_ok,
  input logic              lo_flip_evt,
  input logic              hi_flip_evt,
  input logic              hs_rise_evt
);
  AST_LO_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_sup_ok) |-> ($past(lo_sup_code) >= LO_ON && $past(lo_flip_evt))); // R1
  AST_LO_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_sup_ok) |-> ($past(lo_sup_code) < LO_OFF && $past(lo_flip_evt))); // R1
  AST_HI_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_sup_ok) |-> ($past(hi_sup_code) >= HI_ON && $past(hi_flip_evt))); // R2
  AST_HI_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_sup_ok) |-> ($past(hi_sup_code) < HI_OFF && $past(hi_flip_evt))); // R2
  AST_LO_BAD_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_sup_ok |=> (!lo_drv && !hi_drv)); // R5
  AST_HI_BAD_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_sup_ok |=> !hi_drv); // R6
  AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_sup_ok |=> (lo_drv == $past(lo_cmd))); // R7
  AST_HS_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_drv) |-> $past(hs_rise_evt)); // R8
  AST_HS_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hi_drv |-> $past(hi_cmd)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!lo_drv && !hi_drv && !lo_sup_ok && !hi_sup_ok)); // R9
endmodule

bind supply_lockout_gate supply_lockout_chk #(
  .CODE_W(CODE_W), .LO_ON(LO_ON), .LO_OFF(LO_OFF), .HI_ON(HI_ON), .HI_OFF(HI_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_sup_code(lo_sup_code), .hi_sup_code(hi_sup_code),
  .lo_cmd(lo_cmd), .hi_cmd(hi_cmd), .lo_drv(lo_drv), .hi_drv(hi_drv),
  .lo_sup_ok(lo_sup_ok), .hi_sup_ok(hi_sup_ok), .lo_flip_evt(lo_flip_evt),
  .hi_flip_evt(hi_flip_evt), .hs_rise_evt(hs_rise_evt)
);

// File: tb/supply_lockout_gate_test.sv
module supply_lockout_gate_test;
  localparam int CODE_W = 10;
  localparam int FILT   = 20;
  localparam int SETTLE = FILT + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CODE_W-1:0] lc = '0, hc = '0, mc = '0;
  logic lcmd = 1'b0, hcmd = 1'b0;
  logic lo_drv, hi_drv, lo_ok, hi_ok;
  logic m_lo_drv, m_hi_drv, m_lo_ok, m_hi_ok;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  supply_lockout_gate #(.CODE_W(CODE_W), .FILT_CYC(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .lo_sup_code(lc), .hi_sup_code(hc),
    .lo_cmd(lcmd), .hi_cmd(hcmd), .lo_drv(lo_drv), .hi_drv(hi_drv),
    .lo_sup_ok(lo_ok), .hi_sup_ok(hi_ok));

  supply_lockout_gate #(.CODE_W(CODE_W), .FILT_CYC(FILT),
                        .PROFILE(uvlo_pkg::PROF_MOSFET)) uut_mos (
    .clk(clk), .rst_n(rst_n), .lo_sup_code(mc), .hi_sup_code(mc),
    .lo_cmd(1'b0), .hi_cmd(1'b0), .lo_drv(m_lo_drv), .hi_drv(m_hi_drv),
    .lo_sup_ok(m_lo_ok), .hi_sup_ok(m_hi_ok));

  // {lo code, hi code, lo_cmd, hi_cmd, exp lo_ok, exp hi_ok, exp lo_drv, exp hi_drv}
  localparam logic [25:0] VEC [15] = '{
    {10'd600, 10'd600, 6'b111110},  // R8 edge seen while bad: no turn-on
    {10'd600, 10'd600, 6'b001100},
    {10'd600, 10'd600, 6'b111111},  // R8 edge while good
    {10'd600, 10'd400, 6'b111010},  // R6 high bad only
    {10'd600, 10'd400, 6'b011000},  // R6 low still follows
    {10'd600, 10'd600, 6'b111110},  // R8 held high after recovery
    {10'd600, 10'd600, 6'b101110},
    {10'd600, 10'd600, 6'b011101},
    {10'd400, 10'd600, 6'b110100},  // R5 low bad silences both
    {10'd600, 10'd600, 6'b111110},  // R7 low resumes level, R8 high waits
    {10'd480, 10'd480, 6'b101110},  // R1 band keeps good
    {10'd480, 10'd480, 6'b111111},
    {10'd450, 10'd450, 6'b110100},  // R1 falls, R2 band keeps good
    {10'd480, 10'd450, 6'b110100},  // R1 band keeps bad
    {10'd500, 10'd450, 6'b111110}   // R1 exact ON level, R8 no edge
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R9", "reset lo_ok", lo_ok, 1'b0);
    chk("R9", "reset hi_ok", hi_ok, 1'b0);
    chk("R9", "reset drives", lo_drv | hi_drv, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R9", "after release lo_ok", lo_ok, 1'b0);

    for (int i = 0; i < 15; i++) begin
      lc = VEC[i][25:16]; hc = VEC[i][15:6];
      lcmd = VEC[i][5];   hcmd = VEC[i][4];
      cyc(SETTLE);
      chk("R1", $sformatf("vec%0d lo_ok", i), lo_ok, VEC[i][3]);
      chk("R2", $sformatf("vec%0d hi_ok", i), hi_ok, VEC[i][2]);
      chk("R7", $sformatf("vec%0d lo_drv", i), lo_drv, VEC[i][1]);
      chk("R8", $sformatf("vec%0d hi_drv", i), hi_drv, VEC[i][0]);
    end

    // Exact falling thresholds: equal to OFF stays good, one below goes bad
    lc = 10'd464; hc = 10'd428; cyc(SETTLE);
    chk("R1", "lo at OFF level", lo_ok, 1'b1);
    chk("R2", "hi at OFF level", hi_ok, 1'b1);
    lc = 10'd463; hc = 10'd427; cyc(SETTLE);
    chk("R1", "lo below OFF", lo_ok, 1'b0);
    chk("R2", "hi below OFF", hi_ok, 1'b0);
    hc = 10'd463; cyc(SETTLE);
    chk("R2", "hi just below ON", hi_ok, 1'b0);
    hc = 10'd464; cyc(SETTLE);
    chk("R2", "hi at ON level", hi_ok, 1'b1);

    // Filter window
    lc = 10'd600; hc = 10'd600; lcmd = 1'b1; hcmd = 1'b0; cyc(SETTLE);
    chk("R4", "restored lo_ok", lo_ok, 1'b1);
    lc = 10'd400; cyc(FILT - 1);
    lc = 10'd600; cyc(SETTLE);
    chk("R4", "short dip ignored", lo_ok, 1'b1);
    chk("R4", "short dip lo_drv", lo_drv, 1'b1);
    lc = 10'd400; cyc(FILT - 1);
    chk("R4", "one edge before window", lo_ok, 1'b1);
    cyc(1);
    chk("R4", "flag drops at window end", lo_ok, 1'b0);
    cyc(1);
    chk("R5", "lo_drv off one cycle later", lo_drv, 1'b0);

    // Low-side command following latency
    lc = 10'd600; cyc(SETTLE);
    chk("R7", "lo_drv on after recovery", lo_drv, 1'b1);
    lcmd = 1'b0; cyc(1);
    chk("R7", "lo_drv follows in one cycle", lo_drv, 1'b0);
    hcmd = 1'b1; cyc(1);
    chk("R8", "hi_drv on one cycle after edge", hi_drv, 1'b1);

    // MOSFET profile thresholds on the second instance
    mc = 10'd363; cyc(SETTLE);
    chk("R3", "mos below ON", m_lo_ok | m_hi_ok, 1'b0);
    mc = 10'd364; cyc(SETTLE);
    chk("R3", "mos lo at ON", m_lo_ok, 1'b1);
    chk("R3", "mos hi at ON", m_hi_ok, 1'b1);
    mc = 10'd340; cyc(SETTLE);
    chk("R3", "mos band keeps good", m_lo_ok & m_hi_ok, 1'b1);
    mc = 10'd331; cyc(SETTLE);
    chk("R3", "mos below OFF", m_lo_ok | m_hi_ok, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule